// File: doc/BRIEF.md
# Serial Slave Bit Layer with Transfer Pause

This block is the bit-level front end of a serial memory slave on a four-wire synchronous serial bus (SPI). It runs entirely on a fast system clock. It brings the bus clock, select, data-in and pause pins through two-flop synchronizers and finds their edges in that clock domain. Received bits are assembled into bytes, most significant bit first. Each finished byte is passed to a command engine together with its position in the frame. Reply bytes from the engine are shifted back out on the data-out pin.

A frame opens only on a falling edge of the active-low select. Raising select ends the frame: the output driver is released and any partial byte is dropped. The engine is told when a frame opens and when it closes, and whether it closed exactly on a byte boundary. An active-low pause input freezes the transfer in the middle of a byte. While paused, the output driver is released, and when the pause ends the transfer picks up at the same bit. Opcode meaning, storage and write protection belong to the engine and are not part of this block. Bus clock idle-low (mode 0) and idle-high (mode 3) operation are both handled. The system clock must run at least 8 times faster than the bus clock.

Top module: `spi_hold_frontend`

## Requirements
- R1: Data-in is sampled on each rising bus clock edge. After every 8 sampled bits, `rx_valid` pulses for one cycle. At that pulse, `rx_data` holds the 8 bits with the first-sampled bit at bit 7, and `rx_idx` holds the byte's position in the frame, counting from 0.
- R2: `so` changes only after falling bus clock edges. The first falling edge after a byte boundary drives bit 7 of the reply byte, and each later falling edge drives the next lower bit. The reply byte is `tx_data` if `tx_valid` is high at that edge, and `tx_ready` then pulses for one cycle. Otherwise the reply byte is 0x00. During byte 0 of a frame, `so` is 0.
- R3: While select is high, `so_oe` is 0. Raising select discards any partial byte, and the next frame starts again at bit 0 with `rx_idx` 0.
- R4: After reset, a select that is already low does not open a frame. Until select has been seen high and then low, there is no `frm_start`, no `rx_valid`, and `so_oe` stays 0.
- R5: If the pause input falls while the bus clock is low, the transfer pauses. While paused, `so_oe` is 0 and bus clock and data-in activity are ignored. Once the pause input rises with the bus clock low, the transfer resumes at the bit where it stopped.
- R6: A fall of the pause input while the bus clock is high does not start a pause. A rise of the pause input while the bus clock is high does not end one.
- R7: `frm_start` pulses once for each select falling edge. `frm_end` pulses once when select rises during an open frame. `frm_aligned` is 1 together with `frm_end` exactly when the number of bits received in the frame is a multiple of 8.
- R8: With the bus clock idling high (mode 3), received bytes and replies are the same as in idle-low (mode 0) operation.
- R9: Raising select clears a pause. A new frame starts with the output driven, even if the pause input is still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Bus clock pin |
| cs_n | input | 1 | Active-low select pin |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause pin |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the data-out pad; when 0 the pad is high impedance |
| rx_valid | output | 1 | One-cycle strobe: a received byte is ready |
| rx_data | output | 8 | Received byte |
| rx_idx | output | IDX_W | Position of the byte in the frame, wrapping |
| tx_data | input | 8 | Reply byte offered by the engine |
| tx_valid | input | 1 | Reply byte is available |
| tx_ready | output | 1 | One-cycle strobe: the reply byte was taken |
| frm_start | output | 1 | Frame opened |
| frm_end | output | 1 | Frame closed |
| frm_aligned | output | 1 | The frame closed on a byte boundary (valid with frm_end) |

## Verification
The hardest state to reach from the ports is a pause that sticks. To get there, the pause input must fall with the bus clock low, the bus clock must be driven high, and the pause input must then rise while the clock is high. The bench scripts this sequence inside a byte and checks that the output stays released. It then releases the pause properly and confirms that the byte and the reply arrive intact. A second scripted case drops the pause input while the bus clock is high, keeps it low over the next falling edge, and checks that no pause takes hold.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    // Synchronized pin bundle
    typedef struct packed {
        logic hold_n;
        logic si;
        logic cs_n;
        logic sck;
    } pin_vec_t;

    // Qualified events toward the shift datapath
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } strobe_t;

    function automatic logic edge_up(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

    function automatic logic edge_dn(input logic now_v, input logic was_v);
        return ~now_v & was_v;
    endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins,
    output logic     active,
    output logic     paused,
    output strobe_t  strb
);
    logic prev_sck, prev_cs_n, prev_hold_n;
    logic cs_fall, cs_rise, hold_fall, hold_rise, sck_up, sck_dn, run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sck    <= 1'b0;
            prev_cs_n   <= 1'b0;
            prev_hold_n <= 1'b0;
        end else begin
            prev_sck    <= pins.sck;
            prev_cs_n   <= pins.cs_n;
            prev_hold_n <= pins.hold_n;
        end
    end

    assign cs_fall   = edge_dn(pins.cs_n, prev_cs_n);
    assign cs_rise   = edge_up(pins.cs_n, prev_cs_n);
    assign hold_fall = edge_dn(pins.hold_n, prev_hold_n);
    assign hold_rise = edge_up(pins.hold_n, prev_hold_n);
    assign sck_up    = edge_up(pins.sck, prev_sck);
    assign sck_dn    = edge_dn(pins.sck, prev_sck);

    // A frame opens only on a select falling edge seen after reset
    always_ff @(posedge clk) begin
        if (rst || pins.cs_n) begin
            active <= 1'b0;
        end else if (cs_fall) begin
            active <= 1'b1;
        end
    end

    // Pause enters and leaves only with the bus clock low
    always_ff @(posedge clk) begin
        if (rst || !active || pins.cs_n) begin
            paused <= 1'b0;
        end else if (!paused && hold_fall && !pins.sck) begin
            paused <= 1'b1;
        end else if (paused && hold_rise && !pins.sck) begin
            paused <= 1'b0;
        end
    end

    assign run        = active & ~paused & ~pins.cs_n;
    assign strb.start = cs_fall;
    assign strb.stop  = cs_rise & active;
    assign strb.rise  = run & sck_up;
    assign strb.fall  = run & sck_dn;

    p_pause_low_sck_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(paused) |-> !$past(pins.sck));

    p_release_low_sck_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(paused) && $past(active) && !$past(pins.cs_n)) |-> !$past(pins.sck));

    p_start_from_idle_r4: assert property (@(posedge clk) disable iff (rst)
        strb.start |-> !active);
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
    import spi_fe_pkg::*;
#(
    parameter int                IDX_W = 8,
    parameter logic [BYTE_W-1:0] FILL  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           strb,
    input  logic              si_bit,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic [IDX_W-1:0]  rx_idx,
    output logic              tx_ready,
    output logic              so_bit,
    output logic              on_boundary
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]    rx_sh;
    logic [BYTE_W-1:0]    tx_sh;
    logic [IDX_W-1:0]     byte_cnt;
    logic                 load_pend;
    logic [BYTE_W-1:0]    next_tx;

    assign next_tx     = tx_valid ? tx_data : FILL;
    assign on_boundary = (bit_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || strb.start) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_cnt  <= '0;
            load_pend <= 1'b0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            rx_idx    <= '0;
            tx_ready  <= 1'b0;
            so_bit    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_ready <= 1'b0;
            if (strb.rise) begin
                rx_sh   <= {rx_sh[BYTE_W-3:0], si_bit};
                bit_cnt <= bit_cnt + BIT_CNT_W'(1);
                if (bit_cnt == LAST_BIT) begin
                    rx_valid  <= 1'b1;
                    rx_data   <= {rx_sh, si_bit};
                    rx_idx    <= byte_cnt;
                    byte_cnt  <= byte_cnt + IDX_W'(1);
                    load_pend <= 1'b1;
                end
            end
            if (strb.fall) begin
                if (load_pend) begin
                    load_pend <= 1'b0;
                    tx_ready  <= tx_valid;
                    so_bit    <= next_tx[BYTE_W-1];
                    tx_sh     <= {next_tx[BYTE_W-2:0], 1'b0};
                end else begin
                    so_bit    <= tx_sh[BYTE_W-1];
                    tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    p_single_valid_r1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_take_on_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (bit_cnt == '0));
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
    import spi_fe_pkg::*;
#(
    parameter int                IDX_W     = 8,
    parameter int                SYNC_STGS = 2,
    parameter logic [BYTE_W-1:0] FILL      = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic [IDX_W-1:0]  rx_idx,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              frm_start,
    output logic              frm_end,
    output logic              frm_aligned
);
    localparam int PIN_W = $bits(pin_vec_t);

    pin_vec_t          raw_pins, s_pins;
    logic [PIN_W-1:0]  s_vec;
    logic              active, paused, on_boundary, so_bit;
    strobe_t           strb;

    assign raw_pins = '{hold_n: hold_n, si: si, cs_n: cs_n, sck: sck};

    spi_fe_sync #(.W(PIN_W), .STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (s_vec)
    );
    assign s_pins = pin_vec_t'(s_vec);

    spi_fe_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .pins   (s_pins),
        .active (active),
        .paused (paused),
        .strb   (strb)
    );

    spi_fe_shift #(.IDX_W(IDX_W), .FILL(FILL)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .strb        (strb),
        .si_bit      (s_pins.si),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_idx      (rx_idx),
        .tx_ready    (tx_ready),
        .so_bit      (so_bit),
        .on_boundary (on_boundary)
    );

    assign so          = so_bit;
    assign so_oe       = active & ~paused;
    assign frm_start   = strb.start;
    assign frm_end     = strb.stop;
    assign frm_aligned = strb.stop & on_boundary;

    p_silent_in_pause_r5: assert property (@(posedge clk) disable iff (rst)
        paused |=> !rx_valid);

    p_release_on_deselect_r3: assert property (@(posedge clk) disable iff (rst)
        frm_end |=> !so_oe);
endmodule

// File: tb/spi_hold_frontend_test.sv
module spi_hold_frontend_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst, sck, cs_n, si, hold_n;
    logic       so, so_oe, rx_valid, tx_ready, tx_valid, frm_start, frm_end, frm_aligned;
    logic [7:0] rx_data, rx_idx, tx_data;

    int n_chk = 0, n_fail = 0, start_cnt = 0, end_cnt = 0, ready_cnt = 0;
    bit done = 0, reply_en = 0, exp_align = 0;
    logic [7:0] exp_d[$], exp_i[$];
    int         cur_idx = 0;
    logic [7:0] prev_tx = 0;

    always #10 clk = ~clk;

    spi_hold_frontend uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .rx_valid(rx_valid), .rx_data(rx_data), .rx_idx(rx_idx),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .frm_start(frm_start), .frm_end(frm_end), .frm_aligned(frm_aligned)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor / scoreboard plus a small engine model that answers each byte
    always @(negedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= 8'h00;
        end else begin
            if (rx_valid) begin
                if (exp_d.size() == 0) begin
                    chk(0, "R1/R4", "unexpected byte", rx_data, 0);
                end else begin
                    logic [7:0] ed, ei;
                    ed = exp_d.pop_front();
                    ei = exp_i.pop_front();
                    chk(rx_data == ed, "R1", "rx_data", rx_data, ed);
                    chk(rx_idx == ei, "R1", "rx_idx", rx_idx, ei);
                end
            end
            if (tx_ready) ready_cnt++;
            if (frm_start) start_cnt++;
            if (frm_end) begin
                end_cnt++;
                chk(frm_aligned == exp_align, "R7", "frm_aligned", frm_aligned, exp_align);
            end
            if (frm_start) tx_valid <= 1'b0;
            else if (rx_valid && reply_en) begin
                tx_data  <= rx_data + 8'h11;
                tx_valid <= 1'b1;
            end else if (tx_ready) tx_valid <= 1'b0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_open(input bit m3);
        sck = m3;
        tick(4);
        cs_n = 1'b0;
        cur_idx = 0;
        prev_tx = 8'h00;
        tick(HALF);
    endtask

    task automatic frame_close(input bit aligned);
        exp_align = aligned;
        tick(4);
        cs_n = 1'b1;
        tick(HALF);
        chk(so_oe == 1'b0, "R3", "so_oe after deselect", so_oe, 0);
        sck = 1'b0;
        tick(4);
    endtask

    // R5 scenario: pause at sck low, junk clocks, release at sck low
    task automatic pause_seq();
        hold_n = 1'b0;
        tick(6);
        chk(so_oe == 1'b0, "R5", "so_oe while paused", so_oe, 0);
        for (int k = 0; k < 2; k++) begin
            si = ~si; sck = 1'b1; tick(HALF);
            sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1;
        tick(6);
        chk(so_oe == 1'b1, "R5", "so_oe after release", so_oe, 1);
    endtask

    // R6 scenario: hold edges at sck high are not pause boundaries
    task automatic odd_hold_seq();
        tick(6);
        chk(so_oe == 1'b1, "R6", "no pause from fall at high sck", so_oe, 1);
        hold_n = 1'b1; tick(4);
        hold_n = 1'b0; tick(6);
        sck = 1'b1; tick(4);
        hold_n = 1'b1; tick(6);
        chk(so_oe == 1'b0, "R6", "rise at high sck keeps pause", so_oe, 0);
        sck = 1'b0; tick(4);
        hold_n = 1'b0; tick(4);
        hold_n = 1'b1; tick(6);
        chk(so_oe == 1'b1, "R6", "released at low sck", so_oe, 1);
    endtask

    // scn: 0 plain, 1 pause in byte, 2 odd hold edges in byte (mode 0 only)
    task automatic send_byte(input bit m3, input logic [7:0] tx, input int scn);
        logic [7:0] got, exp_so;
        exp_d.push_back(tx);
        exp_i.push_back(8'(cur_idx));
        exp_so = (cur_idx == 0 || !reply_en) ? 8'h00 : prev_tx + 8'h11;
        for (int i = 7; i >= 0; i--) begin
            if (scn == 1 && i == 4) pause_seq();
            if (scn == 2 && i == 5) odd_hold_seq();
            if (m3) begin
                sck = 1'b0; si = tx[i]; tick(HALF);
                got[i] = so; sck = 1'b1; tick(HALF);
            end else begin
                si = tx[i]; tick(HALF);
                got[i] = so; sck = 1'b1; tick(HALF / 2);
                if (scn == 2 && i == 6) hold_n = 1'b0;
                tick(HALF / 2); sck = 1'b0;
            end
        end
        chk(got == exp_so, m3 ? "R8" : "R2", "so byte", got, exp_so);
        prev_tx = tx;
        cur_idx++;
    endtask

    task automatic send_bits(input int n);
        for (int i = 0; i < n; i++) begin
            si = i[0]; tick(HALF);
            sck = 1'b1; tick(HALF);
            sck = 1'b0;
        end
    endtask

    initial begin
        rst = 1'b1; sck = 1'b0; cs_n = 1'b0; si = 1'b0; hold_n = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(2);
        chk(so_oe == 1'b0, "R4", "so_oe at reset", so_oe, 0);
        chk(rx_valid == 1'b0, "R4", "rx_valid at reset", rx_valid, 0);
        tick(6);
        // R4: select low since reset, clocks must be ignored
        send_bits(16);
        tick(4);
        chk(start_cnt == 0, "R4", "no frame without select edge", start_cnt, 0);
        chk(so_oe == 1'b0, "R4", "so_oe without frame", so_oe, 0);
        cs_n = 1'b1;
        tick(8);

        // R1/R2/R7: mode 0 frame with replies
        reply_en = 1;
        ready_cnt = 0;
        frame_open(0);
        chk(start_cnt == 1, "R7", "frm_start count", start_cnt, 1);
        send_byte(0, 8'hA5, 0);
        chk(so_oe == 1'b1, "R2", "so_oe in frame", so_oe, 1);
        send_byte(0, 8'h3C, 0);
        send_byte(0, 8'h0F, 0);
        send_byte(0, 8'hF0, 0);
        frame_close(1);
        chk(ready_cnt == 4, "R2", "tx_ready pulses", ready_cnt, 4);

        // R2: no reply offered -> zero fill, no tx_ready
        reply_en = 0;
        ready_cnt = 0;
        frame_open(0);
        send_byte(0, 8'h81, 0);
        send_byte(0, 8'h7E, 0);
        frame_close(1);
        chk(ready_cnt == 0, "R2", "no tx_ready without tx_valid", ready_cnt, 0);

        // R8: mode 3
        reply_en = 1;
        frame_open(1);
        send_byte(1, 8'h5A, 0);
        send_byte(1, 8'hC3, 0);
        send_byte(1, 8'h99, 0);
        frame_close(1);

        // R3/R7: partial byte discarded, unaligned end
        frame_open(0);
        send_bits(5);
        frame_close(0);
        frame_open(0);
        send_byte(0, 8'h42, 0);
        frame_close(1);

        // R5/R6: pause scenarios inside a frame
        frame_open(0);
        send_byte(0, 8'h12, 0);
        send_byte(0, 8'hB7, 1);
        send_byte(0, 8'h6D, 2);
        frame_close(1);

        // R9: pause pending at deselect, hold still low at next frame
        frame_open(0);
        send_byte(0, 8'h2E, 0);
        hold_n = 1'b0;
        tick(6);
        chk(so_oe == 1'b0, "R9", "paused before deselect", so_oe, 0);
        frame_close(1);
        frame_open(0);
        tick(2);
        chk(so_oe == 1'b1, "R9", "new frame not paused", so_oe, 1);
        hold_n = 1'b1;
        tick(4);
        send_byte(0, 8'hD4, 0);
        frame_close(1);

        tick(10);
        chk(exp_d.size() == 0, "R1", "bytes outstanding", exp_d.size(), 0);
        chk(start_cnt == 8, "R7", "frm_start total", start_cnt, 8);
        chk(end_cnt == 8, "R7", "frm_end total", end_cnt, 8);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule